// File: doc/BRIEF.md
# Eight-bit timer/counter with waveform generator

This block is an 8-bit counter whose steps come from a system-clock prescaler. It has one compare register and drives a single waveform pin. A control register picks the counting scheme: plain free-running, clear-on-compare with the compare register as the top value, single-slope PWM, or dual-slope PWM. The same register picks what the pin does on a compare event and holds a one-shot strobe that forces a compare action. Two sticky flags record compare events and counter overflow. Software clears a flag by writing a one to its bit.

Software reaches the control, counter, compare and flag registers through a small synchronous write port. Reads are combinational from the address. In the two PWM schemes, a new compare value is held in a staging register and moves into the comparator only at the scheme's update point, so the duty cycle never glitches in the middle of a period.

Register map (address: contents):
- 0: control. Bit 7 is the force strobe. Bit 6 is scheme bit 0. Bits 5:4 are the pin action. Bit 3 is scheme bit 1. Bits 2:0 are the clock select.
- 1: counter.
- 2: compare.
- 3: flags. Bit 0 is the compare flag and bit 1 is the overflow flag.

Top module: `tc8_wavegen`

## Requirements
- R1: After reset, all four registers read zero and the waveform pin is low.
- R2: The control register reads back bit 7 as zero. The other seven bits read back as written. The scheme is encoded as {bit3, bit6}: 00 free-running, 01 dual-slope PWM, 10 clear-on-compare, 11 single-slope PWM.
- R3: The clock select encodes 000 stopped, 001 every clock, 010 every 8 clocks, 011 every 64, 100 every 256 and 101 every 1024. Codes 110 and 111 stop the counter. After a start from stopped, the first step comes after a full divisor period.
- R4: In free-running mode the counter increments and wraps from 0xFF to 0x00. The wrap sets the overflow flag.
- R5: In clear-on-compare mode the counter steps through TOP-1, TOP, 0, 1, where TOP is the compare value. The step out of TOP sets the compare flag.
- R6: In the non-PWM schemes, a control write with bit 7 set applies the pin action immediately. Pin actions are 01 toggle, 10 drive low, 11 drive high. The forced action sets no flag and leaves the counter unchanged.
- R7: When the scheme written with the strobe is a PWM scheme, the strobe has no effect on the pin.
- R8: In the non-PWM schemes, a counter step that leaves a value equal to the compare register applies the pin action and sets the compare flag. Pin action 00 holds the pin low.
- R9: In single-slope PWM with pin action 10, the pin is high exactly while the counter is at or below the compare value. A compare value of 0xFF keeps the pin high.
- R10: In dual-slope PWM the counter runs 0 up to 0xFF and back down to 0. With pin action 10, the pin goes low on an up-count match and high on a down-count match. This scheme never sets the overflow flag.
- R11: In single-slope PWM, a compare write takes effect only once the counter wraps to zero. The compare register reads back the new value at once.
- R12: Writing a one to a flag bit clears that flag and leaves the other flag alone. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr |
| wave_out | output | 1 | Waveform pin |

## Verification
Two functions can land on the same clock edge: the hardware compare event that sets the flag, and a software write that clears that flag. The bench provokes this in clear-on-compare mode. It preloads the counter with TOP, starts the clock at divide-by-one, and issues the flag-clear write on the very next edge, which is the edge where the counter steps out of TOP. It then stops the counter and judges the collision by reading the flag register, which must show the compare flag set. A second, uncontested clear must then bring it back to zero.

// File: rtl/tc8_pkg.sv
package tc8_pkg;
   typedef enum logic [1:0] {
      MODE_FREE  = 2'b00,
      MODE_DUAL  = 2'b01,
      MODE_CTC   = 2'b10,
      MODE_SINGLE = 2'b11
   } tc_mode_e;

   typedef enum logic [1:0] {
      PIN_OFF    = 2'b00,
      PIN_TOGGLE = 2'b01,
      PIN_LOW    = 2'b10,
      PIN_HIGH   = 2'b11
   } tc_pin_e;

   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_CNT  = 2'd1;
   localparam logic [1:0] RA_CMP  = 2'd2;
   localparam logic [1:0] RA_FLAG = 2'd3;

   localparam int NUM_TAPS = 4;
endpackage

// File: rtl/tc8_prescale.sv
module tc8_prescale
   import tc8_pkg::*;
#(
   parameter int DIV_LOG [NUM_TAPS] = '{3, 6, 8, 10}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   localparam int PRE_W = DIV_LOG[NUM_TAPS-1];

   if (DIV_LOG[0] < 1) begin : g_bad_first
      $error("tc8_prescale: first divider exponent must be at least 1");
   end
   for (genvar g = 1; g < NUM_TAPS; g++) begin : g_order
      if (DIV_LOG[g] <= DIV_LOG[g-1]) begin : g_bad
         $error("tc8_prescale: divider exponents must rise strictly");
      end
   end

   logic [PRE_W-1:0]  div_q;
   logic [NUM_TAPS:0] tap_hit;
   logic              run;

   assign run = (sel != 3'd0) && (sel <= 3'd5);

   always_ff @(posedge clk) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else             div_q <= div_q + 1'b1;
   end

   assign tap_hit[0] = 1'b1;
   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      assign tap_hit[g+1] = &div_q[DIV_LOG[g]-1:0];
   end

   always_comb begin
      tick = 1'b0;
      if (run) tick = tap_hit[sel - 3'd1];
   end
endmodule

// File: rtl/tc8_counter.sv
module tc8_counter
   import tc8_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tc_mode_e         mode,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             dir_up,
   output logic             match,
   output logic             wrap_evt,
   output logic             peak_evt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic step, at_max;

   assign step     = tick && !ld_en;
   assign at_max   = (cnt_q == CNT_MAX);
   assign match    = step && (cnt_q == cmp_val);
   assign wrap_evt = step && at_max && (mode == MODE_FREE || mode == MODE_SINGLE);
   assign peak_evt = step && at_max && dir_up && (mode == MODE_DUAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dir_up <= 1'b1;
      end else if (ld_en) begin
         cnt_q <= ld_val;
      end else if (tick) begin
         case (mode)
            MODE_CTC: begin
               cnt_q  <= (cnt_q == cmp_val) ? '0 : cnt_q + 1'b1;
               dir_up <= 1'b1;
            end
            MODE_DUAL: begin
               if (dir_up) begin
                  if (at_max) begin
                     dir_up <= 1'b0;
                     cnt_q  <= cnt_q - 1'b1;
                  end else begin
                     cnt_q  <= cnt_q + 1'b1;
                  end
               end else if (cnt_q == '0) begin
                  dir_up <= 1'b1;
                  cnt_q  <= cnt_q + 1'b1;
               end else begin
                  cnt_q  <= cnt_q - 1'b1;
               end
            end
            default: begin
               cnt_q  <= cnt_q + 1'b1;
               dir_up <= 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/tc8_wave.sv
module tc8_wave
   import tc8_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  tc_mode_e mode,
   input  tc_pin_e  pin_act,
   input  logic     force_s,
   input  tc_pin_e  force_act,
   input  logic     match,
   input  logic     dir_up,
   input  logic     wrap_evt,
   output logic     wave_q
);
   function automatic logic apply_act(tc_pin_e a, logic cur);
      case (a)
         PIN_TOGGLE: return !cur;
         PIN_LOW:    return 1'b0;
         PIN_HIGH:   return 1'b1;
         default:    return cur;
      endcase
   endfunction

   logic wave_d;

   always_comb begin
      wave_d = wave_q;
      if (force_s) begin
         wave_d = apply_act(force_act, wave_q);
      end else begin
         case (mode)
            MODE_SINGLE: begin
               if (wrap_evt) begin
                  if (pin_act == PIN_LOW)       wave_d = 1'b1;
                  else if (pin_act == PIN_HIGH) wave_d = 1'b0;
               end else if (match && pin_act != PIN_TOGGLE) begin
                  wave_d = apply_act(pin_act, wave_q);
               end
            end
            MODE_DUAL: begin
               if (match) begin
                  if (pin_act == PIN_LOW)       wave_d = !dir_up;
                  else if (pin_act == PIN_HIGH) wave_d = dir_up;
               end
            end
            default: begin
               if (match) wave_d = apply_act(pin_act, wave_q);
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) wave_q <= 1'b0;
      else        wave_q <= wave_d;
   end
endmodule

// File: rtl/tc8_wavegen.sv
module tc8_wavegen
   import tc8_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int DIV_LOG [NUM_TAPS] = '{3, 6, 8, 10}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             wave_out
);
   if (CNT_W < 8 || CNT_W > 16) begin : g_bad_width
      $error("tc8_wavegen: CNT_W must lie in 8..16");
   end

   tc_mode_e         mode_q;
   tc_pin_e          pin_q;
   logic [2:0]       cs_q;
   logic [CNT_W-1:0] cmp_buf_q, cmp_act_q, cmp_eff;
   logic             cmp_flag_q, ovf_flag_q;

   logic             wr_ctrl, wr_cmp, wr_flag, cnt_ld;
   tc_mode_e         mode_new;
   logic             force_s;
   logic             tick, match, wrap_evt, peak_evt, dir_up, wave_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pwm_mode, upd_pt;

   assign wr_ctrl  = bus_we && (bus_addr == RA_CTRL);
   assign cnt_ld   = bus_we && (bus_addr == RA_CNT);
   assign wr_cmp   = bus_we && (bus_addr == RA_CMP);
   assign wr_flag  = bus_we && (bus_addr == RA_FLAG);
   assign mode_new = tc_mode_e'({bus_wdata[3], bus_wdata[6]});
   assign force_s  = wr_ctrl && bus_wdata[7] && !mode_new[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_FREE;
         pin_q  <= PIN_OFF;
         cs_q   <= 3'd0;
      end else if (wr_ctrl) begin
         mode_q <= mode_new;
         pin_q  <= tc_pin_e'(bus_wdata[5:4]);
         cs_q   <= bus_wdata[2:0];
      end
   end

   assign pwm_mode = mode_q[0];
   assign upd_pt   = (mode_q == MODE_DUAL) ? peak_evt : wrap_evt;
   assign cmp_eff  = pwm_mode ? cmp_act_q : cmp_buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_buf_q <= '0;
         cmp_act_q <= '0;
      end else begin
         if (wr_cmp) cmp_buf_q <= bus_wdata;
         if (!pwm_mode || upd_pt) cmp_act_q <= cmp_buf_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_flag_q <= 1'b0;
         ovf_flag_q <= 1'b0;
      end else begin
         if (match)                     cmp_flag_q <= 1'b1;
         else if (wr_flag && bus_wdata[0]) cmp_flag_q <= 1'b0;
         if (wrap_evt)                  ovf_flag_q <= 1'b1;
         else if (wr_flag && bus_wdata[1]) ovf_flag_q <= 1'b0;
      end
   end

   tc8_prescale #(.DIV_LOG(DIV_LOG)) u_pre (
      .clk (clk),
      .rst_n (rst_n),
      .sel (cs_q),
      .tick (tick)
   );

   tc8_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (mode_q),
      .cmp_val  (cmp_eff),
      .ld_en    (cnt_ld),
      .ld_val   (bus_wdata),
      .cnt_q    (cnt_q),
      .dir_up   (dir_up),
      .match    (match),
      .wrap_evt (wrap_evt),
      .peak_evt (peak_evt)
   );

   tc8_wave u_wave (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .pin_act   (pin_q),
      .force_s   (force_s),
      .force_act (tc_pin_e'(bus_wdata[5:4])),
      .match     (match),
      .dir_up    (dir_up),
      .wrap_evt  (wrap_evt),
      .wave_q    (wave_q)
   );

   assign wave_out = (pin_q == PIN_OFF || (pwm_mode && pin_q == PIN_TOGGLE)) ? 1'b0 : wave_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CTRL: bus_rdata[7:0] = {1'b0, mode_q[0], pin_q, mode_q[1], cs_q};
         RA_CNT:  bus_rdata      = cnt_q;
         RA_CMP:  bus_rdata      = cmp_buf_q;
         default: bus_rdata[1:0] = {ovf_flag_q, cmp_flag_q};
      endcase
   end
endmodule

// File: rtl/tc8_wavegen_chk.sv
module tc8_wavegen_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [2:0]       cs,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_eff,
   input logic             tick,
   input logic             ld,
   input logic             force_s,
   input logic             cmp_flag,
   input logic             ovf_flag
);
   // R5: leaving TOP in clear-on-compare lands on zero
   a_r5_ctc_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b10 && tick && !ld && cnt == cmp_eff) |=> (cnt == '0));

   // R6: a forced compare leaves the counter where it was
   a_r6_force_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (force_s && !tick && !ld) |=> $stable(cnt));

   // R6: a forced compare does not raise the compare flag
   a_r6_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (force_s && !tick && !cmp_flag) |=> !cmp_flag);

   // R10: overflow rises only from free-running or single-slope PWM
   a_r10_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(mode) == 2'b00 || $past(mode) == 2'b11));

   // R3: a stopped clock select holds the counter
   a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((cs == 3'd0 || cs > 3'd5) && !ld) |=> $stable(cnt));
endmodule

bind tc8_wavegen tc8_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode_q),
   .cs       (cs_q),
   .cnt      (cnt_q),
   .cmp_eff  (cmp_eff),
   .tick     (tick),
   .ld       (cnt_ld),
   .force_s  (force_s),
   .cmp_flag (cmp_flag_q),
   .ovf_flag (ovf_flag_q)
);

// File: tb/tc8_wavegen_test.sv
module tc8_wavegen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       wave_out;
   int         n_chk = 0;
   int         n_err = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   tc8_wavegen uut (
      .clk (clk), .rst_n (rst_n), .bus_we (bus_we), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .wave_out (wave_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int d);
      bus_addr = a;
      #1 d = int'(bus_rdata);
   endtask

   task automatic report;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   // run the counter from zero in free-running mode for m idle cycles plus the stop edge
   task automatic run_div(input logic [2:0] cs, input int m, input int exp);
      int v;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd0, {5'd0, cs});
      repeat (m) @(negedge clk);
      wr(2'd0, 8'h00);
      rd(2'd1, v);
      chk($sformatf("R3 cs=%0d m=%0d", cs, m), v, exp);
   endtask

   task automatic fast_duty(input int ocr);
      int c, bad;
      bad = 0;
      wr(2'd0, 8'h00);
      wr(2'd2, ocr[7:0]);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h69);
      repeat (300) @(negedge clk);
      bus_addr = 2'd1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk); #1 c = int'(bus_rdata);
         if (wave_out != (c <= ocr)) bad++;
      end
      chk($sformatf("R9 duty ocr=%0h mismatches", ocr), bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      int v, c, prev, bad, bad2;
      bit up, nu, wrapped, ew;
      int en;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         chk($sformatf("R1 reg %0d", a), v, 0);
      end
      chk("R1 pin", int'(wave_out), 0);

      // R2 control readback, strobe bit reads zero
      wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 ctrl readback", v, 8'h7F);
      wr(2'd0, 8'h00);

      // R3 prescaler sweep
      for (int m = 0; m < 6; m++) run_div(3'd1, m, m + 1);
      for (int m = 0; m < 20; m++) run_div(3'd2, m, (m + 1) / 8);
      run_div(3'd3, 62, 0);   run_div(3'd3, 63, 1);  run_div(3'd3, 127, 2);
      run_div(3'd4, 254, 0);  run_div(3'd4, 255, 1);
      run_div(3'd5, 1022, 0); run_div(3'd5, 1023, 1);
      run_div(3'd6, 20, 0);   run_div(3'd7, 20, 0);

      // R4 free-running wrap sets overflow
      wr(2'd3, 8'h03); wr(2'd1, 8'hFE); wr(2'd0, 8'h01);
      @(negedge clk);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R4 count after wrap", v, 0);
      rd(2'd3, v); chk("R4 overflow flag", v, 2);
      // R12 clear only the compare flag, overflow remains
      wr(2'd3, 8'h01); rd(2'd3, v); chk("R12 selective clear", v, 2);
      wr(2'd3, 8'h02); rd(2'd3, v); chk("R12 clear overflow", v, 0);
      wr(2'd1, 8'h10); wr(2'd0, 8'h01);
      repeat (9) @(negedge clk);
      wr(2'd0, 8'h00);
      rd(2'd1, v); chk("R4 ten steps", v, 8'h1A);

      // R5 clear-on-compare sweep with TOP=5 from 3
      for (int t = 1; t <= 12; t++) begin
         wr(2'd0, 8'h08); wr(2'd3, 8'h03); wr(2'd2, 8'h05); wr(2'd1, 8'h03);
         wr(2'd0, 8'h09);
         repeat (t - 1) @(negedge clk);
         wr(2'd0, 8'h08);
         rd(2'd1, v); chk($sformatf("R5 count t=%0d", t), v, (3 + t) % 6);
         rd(2'd3, v); chk($sformatf("R5 flag t=%0d", t), v, (3 + t >= 6) ? 1 : 0);
      end
      chk("R8 pin off holds low", int'(wave_out), 0);

      // R6 forced compare in clear-on-compare at TOP
      wr(2'd3, 8'h03); wr(2'd1, 8'h05);
      wr(2'd0, 8'h98); chk("R6 force toggle high", int'(wave_out), 1);
      wr(2'd0, 8'h98); chk("R6 force toggle low", int'(wave_out), 0);
      wr(2'd0, 8'hB8); chk("R6 force high", int'(wave_out), 1);
      wr(2'd0, 8'hA8); chk("R6 force low", int'(wave_out), 0);
      wr(2'd0, 8'hB8); chk("R6 force high again", int'(wave_out), 1);
      rd(2'd0, v); chk("R2 strobe not stored", v, 8'h38);
      rd(2'd1, v); chk("R6 count not cleared", v, 5);
      rd(2'd3, v); chk("R6 no compare flag", v, 0);

      // R7 strobe ignored in the PWM schemes
      wr(2'd0, 8'hE8); chk("R7 single-slope force ignored", int'(wave_out), 1);
      wr(2'd0, 8'hE0); chk("R7 dual-slope force ignored", int'(wave_out), 1);

      // R8 free-running compare toggles the pin
      wr(2'd0, 8'h10); wr(2'd3, 8'h03); wr(2'd2, 8'h03); wr(2'd1, 8'h00);
      wr(2'd0, 8'h11);
      repeat (2) @(negedge clk);
      wr(2'd0, 8'h10);
      rd(2'd1, v); chk("R8 at compare value", v, 3);
      chk("R8 pin before match", int'(wave_out), 1);
      rd(2'd3, v); chk("R8 flag before match", v, 0);
      wr(2'd0, 8'h11); wr(2'd0, 8'h10);
      chk("R8 pin toggled", int'(wave_out), 0);
      rd(2'd3, v); chk("R8 flag set", v, 1);

      // R9 single-slope duty sweep
      fast_duty(0); fast_duty(1); fast_duty(8'h80); fast_duty(8'hFE); fast_duty(8'hFF);

      // R11 staged compare in single-slope PWM
      wr(2'd0, 8'h00); wr(2'd2, 8'h40); wr(2'd1, 8'h00); wr(2'd0, 8'h69);
      repeat (300) @(negedge clk);
      bus_addr = 2'd1;
      #1;
      while (bus_rdata != 8'h10) begin @(negedge clk); #1; end
      wr(2'd2, 8'hC0);
      rd(2'd2, v); chk("R11 compare reads new value", v, 8'hC0);
      bus_addr = 2'd1;
      #1 prev = int'(bus_rdata);
      wrapped = 1'b0; bad = 0;
      for (int i = 0; i < 520; i++) begin
         @(negedge clk); #1 c = int'(bus_rdata);
         if (c < prev) wrapped = 1'b1;
         ew = wrapped ? (c <= 8'hC0) : (c <= 8'h40);
         if (wave_out != ew) bad++;
         prev = c;
      end
      chk("R11 old value until wrap", bad, 0);

      // R10 dual-slope counting and pin
      wr(2'd0, 8'h00); wr(2'd2, 8'h80); wr(2'd1, 8'h00); wr(2'd3, 8'h03);
      wr(2'd0, 8'h61);
      repeat (520) @(negedge clk);
      bus_addr = 2'd1;
      #1 prev = int'(bus_rdata);
      @(negedge clk); #1 c = int'(bus_rdata);
      up = (c > prev); prev = c;
      bad = 0; bad2 = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk); #1 c = int'(bus_rdata);
         en = up ? ((prev == 255) ? 254 : prev + 1) : ((prev == 0) ? 1 : prev - 1);
         nu = up ? (prev != 255) : (prev == 0);
         if (c != en) bad++;
         ew = nu ? (c <= 8'h80) : (c < 8'h80);
         if (wave_out != ew) bad2++;
         up = nu; prev = c;
      end
      chk("R10 count sequence", bad, 0);
      chk("R10 pin pattern", bad2, 0);
      rd(2'd3, v); chk("R10 no overflow", (v >> 1) & 1, 0);

      // R12 hardware set wins against a same-edge clear
      wr(2'd0, 8'h08); wr(2'd2, 8'h05); wr(2'd1, 8'h05); wr(2'd3, 8'h03);
      wr(2'd0, 8'h09);
      wr(2'd3, 8'h01);
      wr(2'd0, 8'h08);
      rd(2'd3, v); chk("R12 set wins collision", v & 1, 1);
      wr(2'd3, 8'h01); rd(2'd3, v); chk("R12 plain clear", v, 0);

      done = 1'b1;
      report();
   end
endmodule